// File: doc/BRIEF.md
# Synchronizable PWM Time-Base Counter

This block is the time base of one PWM channel. A free-running counter advances once per time-base tick. A tick is the system clock divided by a programmable power of two. The counter can run in one of four ways: upward with a wrap to zero, downward with a reload of the period, triangular (up to the period, then back down to zero), or frozen. Zero and period event strobes mark the ends of each cycle for the compare logic that sits next to the block.

Several copies can be locked together. A global gate input stops every time base while it is low and clears each divider. All copies therefore resume with aligned ticks, provided their prescale settings match. A synchronization pulse can force a phase value into the counter. In triangular mode it also sets the direction of travel. The sync can be forwarded to the next instance in a chain, either as is or replaced by the local zero event. Forwarding does not depend on whether this instance loads its own phase.

Top module: `pwm_timebase`

## Requirements
- R1: While reset is asserted and on release, count is 0, dir_down is 0 (counting up), and evt_zero, evt_period and sync_out are 0.
- R2: While tb_gate is low the counter and direction keep their values, no event strobe fires, the divider is cleared, and a sync pulse seen in that time has no later effect.
- R3: With prescale = p (0..7), time-base ticks come every 2^p system clocks. After tb_gate rises, the first counter update takes place on the 2^p-th clock edge at which tb_gate is high.
- R4: In mode 0 (up), each tick adds 1 to the count. A tick at count >= period gives 0, and dir_down is 0.
- R5: In mode 1 (down), each tick subtracts 1 from the count. A tick at count 0 loads period, and dir_down is 1.
- R6: In mode 2 (up-down), the counter rises while dir_down is 0. At count >= period it turns to falling and steps down by one. While dir_down is 1 it falls, and at 0 it turns to rising and steps to 1. With period 0 it stays at 0.
- R7: In mode 3 (hold), ticks without a phase load leave the count and direction unchanged.
- R8: With phase_en high, a sync pulse makes the next tick load phase_val into the count, in place of the normal step. A pulse that arrives between ticks is held until that tick.
- R9: In mode 2, a phase load sets dir_down to phase_dir (1 = falling), whatever the direction was before. The following ticks move in that direction.
- R10: phase_dir has no effect in modes 0 and 1. After a phase load, dir_down is 0 in mode 0 and 1 in mode 1.
- R11: With phase_en low, a sync pulse leaves the count and direction exactly as they would be without it.
- R12: sync_sel selects sync_out, which is registered for one system clock. Value 0 forwards sync_in, whatever phase_en and tb_gate are. Value 1 gives a pulse after each tick at count 0. Values 2 and 3 hold it low.
- R13: evt_zero is high for exactly the one system clock of a tick at which count is 0. evt_period is high for exactly the one system clock of a tick at which count equals period. Neither is high outside a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_gate | input | 1 | Global time-base run gate; low stops ticks and clears the divider |
| prescale | input | PRE_W | Divide exponent, tick every 2^prescale clocks |
| mode | input | 2 | 0 up, 1 down, 2 up-down, 3 hold |
| period | input | CNT_W | Period value |
| phase_val | input | CNT_W | Value loaded on a sync with phase_en |
| phase_en | input | 1 | Allow sync pulses to load the counter |
| phase_dir | input | 1 | Direction after a load in up-down mode (1 = falling) |
| sync_sel | input | 2 | Sync output source: 0 pass, 1 zero event, 2/3 off |
| sync_in | input | 1 | Synchronization input pulse |
| sync_out | output | 1 | Synchronization output for downstream instances |
| count | output | CNT_W | Counter value |
| dir_down | output | 1 | Current direction, 1 = falling |
| evt_zero | output | 1 | Zero event strobe |
| evt_period | output | 1 | Period event strobe |

## Verification
The hardest case to reach from the ports is a sync pulse that lands between two ticks while the prescaler is dividing. In that case the block must hold the pulse for several clocks and then apply it, together with the right direction, on exactly the following tick. Dropping it or applying it early are both wrong. Directed segments set a divide of four and place a single-clock pulse in the middle of a tick interval, with phase_dir both opposite to and equal to the current travel. The random phase then drops pulses at arbitrary offsets, together with gate drops, mode changes and period changes, and a bench model compares every clock.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;

   typedef enum logic [1:0] {
      TB_UP   = 2'd0,
      TB_DOWN = 2'd1,
      TB_UPDN = 2'd2,
      TB_HOLD = 2'd3
   } tb_mode_e;

   typedef enum logic [1:0] {
      SO_PASS = 2'd0,
      SO_ZERO = 2'd1,
      SO_OFF  = 2'd2
   } so_sel_e;

   localparam int PRE_W_MAX = 4;

endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
   parameter int PRE_W  = 3,
   parameter bit DIV_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate_en,
   input  logic [PRE_W-1:0] pre_sel,
   output logic             tick
);

   localparam int MAX_EXP = (1 << PRE_W) - 1;
   localparam int DIV_W   = (MAX_EXP < 1) ? 1 : MAX_EXP;

   generate
      if (DIV_EN) begin : g_div
         logic [DIV_W-1:0] div_q;
         logic [DIV_W-1:0] mask;
         logic [DIV_W-1:0] one_w;

         assign one_w = {{(DIV_W-1){1'b0}}, 1'b1};
         // 2^p - 1 in DIV_W bits; p = DIV_W wraps to all ones
         assign mask  = (one_w << pre_sel) - one_w;
         assign tick  = gate_en && (div_q >= mask);

         always_ff @(posedge clk) begin
            if (!rst_n || !gate_en) begin
               div_q <= '0;
            end else if (tick) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + one_w;
            end
         end
      end else begin : g_nodiv
         logic unused_sel;
         assign unused_sel = ^pre_sel;
         assign tick       = gate_en & ~(unused_sel & ~unused_sel);
      end
   endgenerate

endmodule

// File: rtl/tbase_sync.sv
module tbase_sync
   import pwm_tbase_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       gate_en,
   input  logic       tick,
   input  logic       sync_in,
   input  logic [1:0] sel,
   input  logic       cnt_zero,
   output logic       sync_hit,
   output logic       sync_out
);

   logic pend_q;
   logic so_next;

   // a sync between ticks is kept until the next tick consumes it
   always_ff @(posedge clk) begin
      if (!rst_n || !gate_en) begin
         pend_q <= 1'b0;
      end else if (tick) begin
         pend_q <= 1'b0;
      end else if (sync_in) begin
         pend_q <= 1'b1;
      end
   end

   assign sync_hit = tick & (pend_q | sync_in);

   always_comb begin
      case (sel)
         SO_PASS: so_next = sync_in;
         SO_ZERO: so_next = tick & cnt_zero;
         default: so_next = 1'b0;
      endcase
   end

   generate
      if (OUT_REG) begin : g_reg
         logic so_q;
         always_ff @(posedge clk) begin
            if (!rst_n) so_q <= 1'b0;
            else        so_q <= so_next;
         end
         assign sync_out = so_q;
      end else begin : g_comb
         assign sync_out = so_next;
      end
   endgenerate

endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
   import pwm_tbase_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             sync_hit,
   input  logic             phase_en,
   input  logic             phase_dir,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] phase_val,
   output logic [CNT_W-1:0] count,
   output logic             dir_down,
   output logic             cnt_zero,
   output logic             evt_zero,
   output logic             evt_period
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             dir_q, dir_d;
   logic             at_top;

   assign cnt_zero = (cnt_q == '0);
   assign at_top   = (cnt_q >= period);

   always_comb begin
      cnt_d = cnt_q;
      dir_d = dir_q;
      if (tick) begin
         if (sync_hit && phase_en) begin
            cnt_d = phase_val;
            case (mode)
               TB_UP:   dir_d = 1'b0;
               TB_DOWN: dir_d = 1'b1;
               TB_UPDN: dir_d = phase_dir;
               default: dir_d = dir_q;
            endcase
         end else begin
            case (mode)
               TB_UP: begin
                  dir_d = 1'b0;
                  cnt_d = at_top ? '0 : cnt_q + ONE;
               end
               TB_DOWN: begin
                  dir_d = 1'b1;
                  cnt_d = cnt_zero ? period : cnt_q - ONE;
               end
               TB_UPDN: begin
                  if (!dir_q) begin
                     if (at_top) begin
                        dir_d = 1'b1;
                        cnt_d = cnt_zero ? '0 : cnt_q - ONE;
                     end else begin
                        cnt_d = cnt_q + ONE;
                     end
                  end else begin
                     if (cnt_zero) begin
                        dir_d = 1'b0;
                        cnt_d = (period == '0) ? '0 : ONE;
                     end else begin
                        cnt_d = cnt_q - ONE;
                     end
                  end
               end
               default: begin
                  cnt_d = cnt_q;
                  dir_d = dir_q;
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dir_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         dir_q <= dir_d;
      end
   end

   assign count      = cnt_q;
   assign dir_down   = dir_q;
   assign evt_zero   = tick & cnt_zero;
   assign evt_period = tick & (cnt_q == period);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
   import pwm_tbase_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int PRE_W        = 3,
   parameter bit DIV_EN       = 1'b1,
   parameter bit SYNC_OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tb_gate,
   input  logic [PRE_W-1:0] prescale,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] phase_val,
   input  logic             phase_en,
   input  logic             phase_dir,
   input  logic [1:0]       sync_sel,
   input  logic             sync_in,
   output logic             sync_out,
   output logic [CNT_W-1:0] count,
   output logic             dir_down,
   output logic             evt_zero,
   output logic             evt_period
);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("pwm_timebase: CNT_W must be at least 2");
      end
      if (PRE_W < 1 || PRE_W > PRE_W_MAX) begin : g_bad_pre
         $error("pwm_timebase: PRE_W out of range");
      end
   endgenerate

   logic tick_w;
   logic sync_hit_w;
   logic cnt_zero_w;

   tbase_prescaler #(
      .PRE_W  (PRE_W),
      .DIV_EN (DIV_EN)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .gate_en (tb_gate),
      .pre_sel (prescale),
      .tick    (tick_w)
   );

   tbase_sync #(
      .OUT_REG (SYNC_OUT_REG)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate_en  (tb_gate),
      .tick     (tick_w),
      .sync_in  (sync_in),
      .sel      (sync_sel),
      .cnt_zero (cnt_zero_w),
      .sync_hit (sync_hit_w),
      .sync_out (sync_out)
   );

   tbase_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick_w),
      .sync_hit   (sync_hit_w),
      .phase_en   (phase_en),
      .phase_dir  (phase_dir),
      .mode       (mode),
      .period     (period),
      .phase_val  (phase_val),
      .count      (count),
      .dir_down   (dir_down),
      .cnt_zero   (cnt_zero_w),
      .evt_zero   (evt_zero),
      .evt_period (evt_period)
   );

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
   import pwm_tbase_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tb_gate,
   input logic [1:0]       mode,
   input logic [CNT_W-1:0] period,
   input logic [CNT_W-1:0] phase_val,
   input logic             phase_en,
   input logic             phase_dir,
   input logic [1:0]       sync_sel,
   input logic             sync_in,
   input logic             sync_out,
   input logic [CNT_W-1:0] count,
   input logic             dir_down,
   input logic             evt_zero,
   input logic             evt_period,
   input logic             tick,
   input logic             sync_hit
);

   p_gate_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tb_gate |=> ($stable(count) && $stable(dir_down)));

   p_up_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !sync_hit && mode == TB_UP && count < period)
      |=> (count == $past(count) + 1'b1));

   p_up_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !sync_hit && mode == TB_UP && count >= period)
      |=> (count == '0));

   p_down_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !sync_hit && mode == TB_DOWN && count == '0)
      |=> (count == $past(period)));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !sync_hit && mode == TB_HOLD) |=> $stable(count));

   p_phase_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sync_hit && phase_en) |=> (count == $past(phase_val)));

   p_phase_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sync_hit && phase_en && mode == TB_UPDN)
      |=> (dir_down == $past(phase_dir)));

   p_dir_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (mode == TB_UP || mode == TB_DOWN))
      |=> (dir_down == ($past(mode) == TB_DOWN)));

   p_sync_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_sel == SO_PASS) |=> (sync_out == $past(sync_in)));

   p_sync_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_sel == SO_ZERO && evt_zero) |=> sync_out);

   p_evt_in_tick_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_zero || evt_period) |-> tick);

   p_evt_val_r13: assert property (@(posedge clk) disable iff (!rst_n)
      evt_period |-> (count == period));

endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tb_gate    (tb_gate),
   .mode       (mode),
   .period     (period),
   .phase_val  (phase_val),
   .phase_en   (phase_en),
   .phase_dir  (phase_dir),
   .sync_sel   (sync_sel),
   .sync_in    (sync_in),
   .sync_out   (sync_out),
   .count      (count),
   .dir_down   (dir_down),
   .evt_zero   (evt_zero),
   .evt_period (evt_period),
   .tick       (tick_w),
   .sync_hit   (sync_hit_w)
);

// File: tb/sim_pwm_timebase.sv
module sim_pwm_timebase;

   localparam int CLK_P = 10;
   localparam int CW    = 16;
   localparam int PW    = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          tb_gate;
   logic [PW-1:0] prescale;
   logic [1:0]    mode;
   logic [CW-1:0] period;
   logic [CW-1:0] phase_val;
   logic          phase_en;
   logic          phase_dir;
   logic [1:0]    sync_sel;
   logic          sync_in;
   logic          sync_out;
   logic [CW-1:0] count;
   logic          dir_down;
   logic          evt_zero;
   logic          evt_period;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   // bench reference state
   int m_div;
   bit m_pend;
   int m_cnt;
   bit m_dir;
   bit m_so;

   always #(CLK_P/2) clk = ~clk;

   pwm_timebase #(.CNT_W(CW), .PRE_W(PW)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .tb_gate    (tb_gate),
      .prescale   (prescale),
      .mode       (mode),
      .period     (period),
      .phase_val  (phase_val),
      .phase_en   (phase_en),
      .phase_dir  (phase_dir),
      .sync_sel   (sync_sel),
      .sync_in    (sync_in),
      .sync_out   (sync_out),
      .count      (count),
      .dir_down   (dir_down),
      .evt_zero   (evt_zero),
      .evt_period (evt_period)
   );

   function automatic bit f_tick();
      int mask;
      mask = (1 << prescale) - 1;
      return tb_gate && (m_div >= mask);
   endfunction

   function automatic logic [19:0] f_expect();
      bit t;
      t = f_tick();
      return {m_cnt[15:0], m_dir, t && (m_cnt == 0),
              t && (m_cnt == int'(period)), m_so};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_div = 0; m_pend = 0; m_cnt = 0; m_dir = 0; m_so = 0;
      end else begin
         bit t, hit;
         int p;
         t   = f_tick();
         hit = t && (m_pend || sync_in);
         p   = int'(period);
         case (sync_sel)
            2'd0:    m_so = sync_in;
            2'd1:    m_so = t && (m_cnt == 0);
            default: m_so = 1'b0;
         endcase
         if (t) begin
            if (hit && phase_en) begin
               m_cnt = int'(phase_val);
               if (mode == 2'd0) m_dir = 0;
               else if (mode == 2'd1) m_dir = 1;
               else if (mode == 2'd2) m_dir = phase_dir;
            end else if (mode == 2'd0) begin
               m_dir = 0;
               m_cnt = (m_cnt >= p) ? 0 : m_cnt + 1;
            end else if (mode == 2'd1) begin
               m_dir = 1;
               m_cnt = (m_cnt == 0) ? p : m_cnt - 1;
            end else if (mode == 2'd2) begin
               if (!m_dir) begin
                  if (m_cnt >= p) begin
                     m_dir = 1;
                     m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
                  end else m_cnt = m_cnt + 1;
               end else begin
                  if (m_cnt == 0) begin
                     m_dir = 0;
                     m_cnt = (p == 0) ? 0 : 1;
                  end else m_cnt = m_cnt - 1;
               end
            end
         end
         if (!tb_gate || t) m_pend = 0;
         else if (sync_in)  m_pend = 1;
         if (!tb_gate || t) m_div = 0;
         else               m_div = m_div + 1;
      end
   end

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // advance one clock, then compare all outputs against the model
   task automatic step(input string tag);
      logic [19:0] act, exp;
      @(negedge clk);
      act = {count, dir_down, evt_zero, evt_period, sync_out};
      exp = f_expect();
      check(act === exp, tag, {12'd0, act}, {12'd0, exp});
   endtask

   task automatic steps(input int n, input string tag);
      for (int i = 0; i < n; i++) step(tag);
   endtask

   task automatic pulse_sync(input string tag);
      sync_in = 1'b1;
      step(tag);
      sync_in = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0; tb_gate = 1'b0; prescale = '0; mode = 2'd0;
      period = 16'd4; phase_val = '0; phase_en = 1'b0; phase_dir = 1'b0;
      sync_sel = 2'd2; sync_in = 1'b0;
      steps(3, "R1");
      check({count, dir_down, evt_zero, evt_period, sync_out} === '0, "R1",
            {12'd0, count, dir_down, evt_zero, evt_period, sync_out}, 32'd0);
      rst_n = 1'b1;

      // R2: gate low, sync with phase enabled must be forgotten
      phase_en = 1'b1; phase_val = 16'd3;
      steps(2, "R2");
      pulse_sync("R2");
      steps(4, "R2");
      check(count === 16'd0, "R2", {16'd0, count}, 32'd0);

      // R4: up count with period 4
      tb_gate = 1'b1; phase_en = 1'b0;
      steps(5, "R4");
      check(count === 16'd0, "R4", {16'd0, count}, 32'd0);
      steps(10, "R4");

      // R3: divide by four, gate re-raised
      tb_gate = 1'b0; step("R3");
      prescale = 3'd2; tb_gate = 1'b1;
      steps(3, "R3");
      check(count === 16'd0, "R3", {16'd0, count}, 32'd0);
      step("R3");
      check(count === 16'd1, "R3", {16'd0, count}, 32'd1);
      steps(16, "R3");

      // R5, R6, R7 at full rate
      prescale = 3'd0; mode = 2'd1; steps(14, "R5");
      mode = 2'd2; period = 16'd5; steps(24, "R6");
      period = 16'd0; steps(4, "R6");
      period = 16'd5; mode = 2'd3; steps(6, "R7");

      // R8 / R9: sync mid-interval with divide by four, up-down
      mode = 2'd2; steps(8, "R6");
      prescale = 3'd2; phase_en = 1'b1; phase_val = 16'd3; phase_dir = 1'b1;
      steps(2, "R8");
      pulse_sync("R8");
      steps(10, "R9");
      phase_dir = 1'b0; phase_val = 16'd4;
      steps(1, "R9");
      pulse_sync("R9");
      steps(12, "R9");

      // R10: phase_dir ignored in up and down modes
      prescale = 3'd0; mode = 2'd0; phase_dir = 1'b1;
      pulse_sync("R10");
      steps(3, "R10");
      check(dir_down === 1'b0, "R10", {31'd0, dir_down}, 32'd0);
      mode = 2'd1; phase_dir = 1'b0;
      pulse_sync("R10");
      steps(3, "R10");
      check(dir_down === 1'b1, "R10", {31'd0, dir_down}, 32'd1);

      // R11 with R12 pass-through
      phase_en = 1'b0; sync_sel = 2'd0; mode = 2'd2;
      pulse_sync("R11");
      step("R12");
      steps(6, "R11");
      tb_gate = 1'b0;
      pulse_sync("R12");
      step("R12");
      tb_gate = 1'b1;
      sync_sel = 2'd1; mode = 2'd0; period = 16'd3; steps(12, "R12");
      sync_sel = 2'd3; pulse_sync("R12"); steps(6, "R12");

      // random mix, R13 strobes checked on every clock
      for (int i = 0; i < 4000; i++) begin
         if ($urandom % 40 == 0) mode = 2'($urandom);
         if ($urandom % 60 == 0) period = 16'($urandom % 24);
         if ($urandom % 30 == 0) phase_val = 16'($urandom % 30);
         if ($urandom % 50 == 0) prescale = 3'($urandom % 4);
         if ($urandom % 20 == 0) phase_en = ~phase_en;
         if ($urandom % 20 == 0) phase_dir = ~phase_dir;
         if ($urandom % 70 == 0) sync_sel = 2'($urandom);
         if ($urandom % 90 == 0) tb_gate = ~tb_gate;
         sync_in = ($urandom % 9 == 0);
         step("R13");
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         failures++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule